// File: doc/BRIEF.md
# Flash Controller Interrupt and DMA Request Unit

This unit sits beside a NAND flash controller core. It turns one-cycle event pulses from that core into sticky flags and masks those flags with per-source enable bits. From the result it drives registered interrupt lines toward the CPU. It also gates the FIFO transfer requests into DMA request outputs, using software enable bits and the current access mode: sector access or command access.

Software sees three registers through a simple read and write port. The flag register is read and cleared by writing 1 to a bit. The interrupt-enable register and the DMA-control register are read and written. Overrun and underrun events for both FIFOs are recorded as flags, but they never reach an interrupt line. The flash sequencer, the ECC logic, the FIFOs and the DMA engine are outside this unit and appear here only as inputs.

Top module: `flirq_top`

## Requirements
- R1: After reset, all flags, interrupt enables and DMA enables are 0. The mode is command access. All interrupt lines and DMA requests are low.
- R2: A 1 on `ev_pulse_i[k]` sets flag k, and the flag stays set until software clears it. Flag bit positions are: 0 status error, 1 ready/busy timeout, 2 ECC error, 3 transfer end, 4 FIFO0 transfer request, 5 FIFO1 transfer request, 6 FIFO0 overrun, 7 FIFO0 underrun, 8 FIFO1 overrun, 9 FIFO1 underrun.
- R3: A write to address 0 clears each flag whose data bit is 1 and leaves the other flags unchanged. If an event and a clear hit the same flag in the same cycle, the flag ends up set.
- R4: Each interrupt line is a register. It reflects a flag or enable change at the clock edge after the one that changed that flag or enable.
- R5: `irq_err_o` is the OR of (status error flag AND enable bit 0) and (ready/busy timeout flag AND enable bit 1).
- R6: `irq_ecc_o`, `irq_xend_o`, `irq_fifo0_o` and `irq_fifo1_o` each follow one flag (2, 3, 4, 5) ANDed with the enable bit of the same index (2, 3, 4, 5). Giving the ECC error its own line is an assumption of this design.
- R7: Flags 6 to 9 never assert any interrupt line, whatever the enables are.
- R8: `dma_data_req_o` equals `data_fifo_req_i` AND DMA-control bit 0, in either mode.
- R9: `dma_code_req_o` equals `code_fifo_req_i` AND DMA-control bit 1 AND DMA-control bit 2. Bit 2 set to 1 selects sector access, and 0 selects command access.
- R10: The register map is: address 0 holds the flags, address 1 holds the six enable bits, and address 2 holds the DMA-control bits. Address 3 and all unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ev_pulse_i | input | 10 | One-cycle event pulses, one per flag |
| data_fifo_req_i | input | 1 | Transfer request from the data FIFO |
| code_fifo_req_i | input | 1 | Transfer request from the control-code FIFO |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | 16 | Register write data |
| rd_addr_i | input | 2 | Register read address |
| rd_data_o | output | 16 | Register read data (combinational) |
| irq_err_o | output | 1 | Shared status-error / timeout interrupt |
| irq_ecc_o | output | 1 | ECC error interrupt |
| irq_xend_o | output | 1 | Transfer-end interrupt |
| irq_fifo0_o | output | 1 | FIFO0 transfer-request interrupt |
| irq_fifo1_o | output | 1 | FIFO1 transfer-request interrupt |
| dma_data_req_o | output | 1 | DMA request for the data FIFO |
| dma_code_req_o | output | 1 | DMA request for the control-code FIFO |

## Verification
The assertions check several behaviours on every cycle:
- an event always sets its flag;
- a flag that is not being cleared holds;
- every enabled flag raises its line one edge later, and the shared error line follows either of its sources;
- the control-code DMA request never asserts in command access mode.

Some behaviours need the bench's scenarios instead:
- R7, that the overrun and underrun flags reach no line;
- exact readback values and the partial-clear pattern;
- the one-cycle lag of R4 seen at the ports;
- the full truth tables of both DMA requests.

The bench covers these by sweeping all 64 enable patterns, all 64 flag patterns and all 32 DMA input combinations.

// File: rtl/flirq_pkg.sv
package flirq_pkg;
  localparam int N_SRC  = 6;
  localparam int N_FLAG = 10;
  localparam int N_LINE = 5;
  localparam int REG_W  = 16;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_DMA  = ADDR_W'(2);

  typedef struct packed {
    logic sector;   // 1: sector access, 0: command access
    logic code_en;
    logic data_en;
  } dma_ctl_t;

  localparam int DMA_W = $bits(dma_ctl_t);

  // Sources feeding each interrupt line; line 0 is shared by sources 0 and 1.
  function automatic logic [N_SRC-1:0] line_mask(input int l);
    if (l == 0) return N_SRC'(3);
    return N_SRC'(1) << (l + 1);
  endfunction
endpackage

// File: rtl/flirq_flags.sv
module flirq_flags
  import flirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_FLAG-1:0] ev,
  input  logic [N_FLAG-1:0] clr,
  output logic [N_FLAG-1:0] flag_q
);
  logic [N_FLAG-1:0] flag_d;
  logic [N_FLAG-1:0] upd;

  for (genvar i = 0; i < N_FLAG; i++) begin : g_flag
    always_comb begin
      upd[i]    = ev[i] | clr[i];
      flag_d[i] = ev[i] | (flag_q[i] & ~clr[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag_q[i] <= 1'b0;
      else if (upd[i]) flag_q[i] <= flag_d[i];
    end

    a_r3_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      ev[i] |=> flag_q[i]);
    a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[i] && !clr[i]) |=> flag_q[i]);
  end
endmodule

// File: rtl/flirq_regs.sv
module flirq_regs
  import flirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [N_FLAG-1:0] flags,
  output logic [REG_W-1:0]  rd_data,
  output logic [N_FLAG-1:0] clr,
  output logic [N_SRC-1:0]  ien_q,
  output dma_ctl_t          dma_q
);
  logic [N_SRC-1:0] ien_d;
  dma_ctl_t         dma_d;
  logic             ien_we, dma_we;
  logic             unused_hi;

  assign unused_hi = ^wr_data[REG_W-1:N_FLAG];

  always_comb begin
    ien_we = wr_en && (wr_addr == A_IEN);
    dma_we = wr_en && (wr_addr == A_DMA);
    ien_d  = wr_data[N_SRC-1:0];
    dma_d  = dma_ctl_t'(wr_data[DMA_W-1:0]);
    clr    = (wr_en && (wr_addr == A_FLAG)) ? wr_data[N_FLAG-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ien_q <= '0;
    else if (ien_we) ien_q <= ien_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dma_q <= '0;
    else if (dma_we) dma_q <= dma_d;
  end

  always_comb begin
    case (rd_addr)
      A_FLAG:  rd_data = REG_W'(flags);
      A_IEN:   rd_data = REG_W'(ien_q);
      A_DMA:   rd_data = REG_W'(dma_q);
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/flirq_lines.sv
module flirq_lines
  import flirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src_flag,
  input  logic [N_SRC-1:0]  ien,
  output logic [N_LINE-1:0] irq_q
);
  logic [N_LINE-1:0] hit;

  for (genvar l = 0; l < N_LINE; l++) begin : g_line
    always_comb hit[l] = |(src_flag & ien & line_mask(l));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q[l] <= 1'b0;
      else        irq_q[l] <= hit[l];
    end

    a_r4_line_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (|(src_flag & ien & line_mask(l))) |=> irq_q[l]);
    a_r4_line_drops: assert property (@(posedge clk) disable iff (!rst_n)
      !(|(src_flag & ien & line_mask(l))) |=> !irq_q[l]);
  end
endmodule

// File: rtl/flirq_dma.sv
module flirq_dma
  import flirq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     data_req,
  input  logic     code_req,
  input  dma_ctl_t ctl,
  output logic     dma_data,
  output logic     dma_code
);
  logic code_allowed;

  always_comb begin
    code_allowed = ctl.sector;
    dma_data     = data_req & ctl.data_en;
    dma_code     = code_req & ctl.code_en & code_allowed;
  end

  a_r9_no_code_in_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.sector |-> !dma_code);
  a_r8_data_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    dma_data |-> data_req);
endmodule

// File: rtl/flirq_top.sv
module flirq_top
  import flirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_FLAG-1:0] ev_pulse_i,
  input  logic              data_fifo_req_i,
  input  logic              code_fifo_req_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [REG_W-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [REG_W-1:0]  rd_data_o,
  output logic              irq_err_o,
  output logic              irq_ecc_o,
  output logic              irq_xend_o,
  output logic              irq_fifo0_o,
  output logic              irq_fifo1_o,
  output logic              dma_data_req_o,
  output logic              dma_code_req_o
);
  logic [N_FLAG-1:0] flags, clr;
  logic [N_SRC-1:0]  ien;
  logic [N_LINE-1:0] irq;
  dma_ctl_t          dma_ctl;

  flirq_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .wr_addr(wr_addr_i),
    .wr_data(wr_data_i), .rd_addr(rd_addr_i), .flags(flags),
    .rd_data(rd_data_o), .clr(clr), .ien_q(ien), .dma_q(dma_ctl)
  );

  flirq_flags u_flags (
    .clk(clk), .rst_n(rst_n), .ev(ev_pulse_i), .clr(clr), .flag_q(flags)
  );

  // Overrun/underrun flags (upper bits) are not routed to any line (R7).
  flirq_lines u_lines (
    .clk(clk), .rst_n(rst_n), .src_flag(flags[N_SRC-1:0]), .ien(ien),
    .irq_q(irq)
  );

  flirq_dma u_dma (
    .clk(clk), .rst_n(rst_n), .data_req(data_fifo_req_i),
    .code_req(code_fifo_req_i), .ctl(dma_ctl),
    .dma_data(dma_data_req_o), .dma_code(dma_code_req_o)
  );

  assign irq_err_o   = irq[0];
  assign irq_ecc_o   = irq[1];
  assign irq_xend_o  = irq[2];
  assign irq_fifo0_o = irq[3];
  assign irq_fifo1_o = irq[4];

  a_r5_err_shared_tmo: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[1] && ien[1]) |=> irq_err_o);
  a_r5_err_shared_stat: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[0] && ien[0]) |=> irq_err_o);
endmodule

// File: tb/sim_flirq_top.sv
module sim_flirq_top;
  localparam time CLK_P = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  ev = '0;
  logic        dreq = 1'b0, creq = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        i_err, i_ecc, i_xend, i_f0, i_f1, d_dma, c_dma;
  int          checks = 0, fails = 0;

  always #(CLK_P/2) clk = ~clk;

  flirq_top u0 (
    .clk(clk), .rst_n(rst_n), .ev_pulse_i(ev), .data_fifo_req_i(dreq),
    .code_fifo_req_i(creq), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .irq_err_o(i_err), .irq_ecc_o(i_ecc), .irq_xend_o(i_xend),
    .irq_fifo0_o(i_f0), .irq_fifo1_o(i_f1),
    .dma_data_req_o(d_dma), .dma_code_req_o(c_dma)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] exp_lines(input logic [5:0] f, input logic [5:0] e);
    logic [5:0] m = f & e;
    return {m[5], m[4], m[3], m[2], m[1] | m[0]};
  endfunction

  function automatic logic [15:0] lines();
    return {11'd0, i_f1, i_f0, i_xend, i_ecc, i_err};
  endfunction

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse(input logic [9:0] m);
    @(negedge clk); ev = m;
    @(negedge clk); ev = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  initial begin
    #(CLK_P * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] v;
    dreq = 1'b1; creq = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(2'd0, v); chk("R1 flags", v, 16'h0);
    rd(2'd1, v); chk("R1 ien", v, 16'h0);
    rd(2'd2, v); chk("R1 dma ctl/mode", v, 16'h0);
    chk("R1 lines", lines(), 16'h0);
    chk("R1 dma", {14'd0, c_dma, d_dma}, 16'h0);

    // R4 one-cycle lag after an enable write
    pulse(10'h001);
    wr(2'd1, 16'h0001);
    chk("R4 lag before edge", lines(), 16'h0);
    @(negedge clk);
    chk("R4 after edge", lines(), 16'h1);

    // R5/R6 sweep of all enable patterns with all source flags set
    pulse(10'h03F);
    for (int e = 0; e < 64; e++) begin
      wr(2'd1, 16'(e));
      @(negedge clk);
      chk("R5/R6 enable sweep", lines(), 16'(exp_lines(6'h3F, 6'(e))));
      rd(2'd1, v); chk("R10 ien readback", v, 16'(e));
    end

    // R2/R5/R6 sweep of all flag patterns, all enabled
    wr(2'd1, 16'h003F);
    for (int m = 0; m < 64; m++) begin
      wr(2'd0, 16'h03FF);
      pulse(10'(m));
      @(negedge clk);
      chk("R5/R6 flag sweep", lines(), 16'(exp_lines(6'(m), 6'h3F)));
      rd(2'd0, v); chk("R2 flag readback", v, 16'(m));
    end

    // R7 overrun/underrun flags recorded but never interrupt
    wr(2'd0, 16'h03FF);
    pulse(10'h3C0);
    repeat (2) @(negedge clk);
    chk("R7 no irq from ovr/udr", lines(), 16'h0);
    rd(2'd0, v); chk("R7 ovr/udr recorded", v, 16'h03C0);
    repeat (5) @(negedge clk);
    rd(2'd0, v); chk("R2 sticky over idle", v, 16'h03C0);

    // R3 partial clear
    pulse(10'h3FF);
    wr(2'd0, 16'h0005);
    rd(2'd0, v); chk("R3 partial clear", v, 16'h03FA);
    // R3 set wins over clear in the same cycle
    @(negedge clk); ev = 10'h008; wr_en = 1'b1; wr_addr = 2'd0; wr_data = 16'h0018;
    @(negedge clk); ev = '0; wr_en = 1'b0;
    rd(2'd0, v); chk("R3 set wins", v, 16'h03EA);

    // R10 unused address
    rd(2'd3, v); chk("R10 addr3 zero", v, 16'h0);

    // R8/R9 DMA truth table; bit0 data_en, bit1 code_en, bit2 sector
    for (int c = 0; c < 32; c++) begin
      logic [4:0] b = 5'(c);
      wr(2'd2, {13'd0, b[4:2]});
      dreq = b[0]; creq = b[1]; #1;
      chk("R8 data dma", {15'd0, d_dma}, {15'd0, b[0] & b[2]});
      chk("R9 code dma", {15'd0, c_dma}, {15'd0, b[1] & b[3] & b[4]});
      rd(2'd2, v); chk("R10 dma readback", v, {13'd0, b[4:2]});
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule